// File: doc/BRIEF.md
# Programmable Device Configuration Loader

This block loads a configuration image into a programmable device through the device's byte-wide slave port. It drives two active-low lines toward the device. One is the program (erase) request. The other is a combined select-and-write enable. It also watches the device's two open-drain status lines, the ready-for-data line (INIT) and the configured line (DONE). Image bytes come from a local source over a valid/ready stream. A marker on the final byte ends the stream.

A single `start` pulse runs the whole sequence:

1. Release select, then pull program low.
2. Wait for the device to report that it is clearing.
3. Release program and wait for the device to report that it is ready.
4. Stream bytes with select held low.
5. Allow a drain interval, release select, and wait again.

The block then classifies the final state of the status lines. It ends with a one-cycle result pulse that carries a result code and the number of bytes written. Every wait is measured in ticks, and the length of a tick in clock cycles is a parameter.

Top module: `cfg_loader`

## Requirements
- R1: After reset, and whenever idle, `prog_n` and `csw_n` are high and `s_ready`, `busy`, `result_valid` and `dev_wr` are low. `byte_count` and `result_code` reset to 0.
- R2: After a `start` accepted while idle, `csw_n` stays high and `prog_n` goes low. `prog_n` stays low until both INIT and DONE read low. If that does not happen within WAIT_TICKS ticks, the result code is 2 (clear timeout) and the byte count is 0.
- R3: After `prog_n` is released, the block waits for INIT to read high. If INIT is still low after WAIT_TICKS ticks, the result code is 3 (ready timeout) and no byte is written.
- R4: While streaming, `csw_n` is low, and `csw_n` is low only while `prog_n` is high. Each byte accepted on the stream appears on `dev_data` with a one-cycle `dev_wr` pulse, in source order. `byte_count` increases by one for each such pulse.
- R5: After each accepted byte, `s_ready` stays low for SYNC_STAGES+2 cycles so the device's answer to that byte can pass the synchronizers. Streaming then stops if DONE reads high, INIT reads low, or the byte carried `s_last`. A device that reacts within one cycle of a write therefore gets exactly the bytes up to and including the byte that tripped it.
- R6: When streaming stops, `csw_n` stays low for DRAIN_TICKS ticks, then goes high. `result_valid` follows exactly DRAIN_TICKS*TICK_CYCLES+1 cycles after `csw_n` rises.
- R7: The final classification uses this priority. INIT low gives code 4 (checksum failure). Otherwise DONE low gives code 5 (incomplete image). Otherwise the code is 1 (success).
- R8: `result_valid` is a single-cycle pulse. `result_code` and `byte_count` hold their values until the next accepted `start`. The cycle after the pulse, the block is idle with `prog_n` and `csw_n` high.
- R9: A `start` pulse while `busy` is high has no effect. The running load continues and `prog_n` does not fall again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load (taken only when idle) |
| s_data | input | DATA_W | Image byte from the source |
| s_valid | input | 1 | Source byte valid |
| s_last | input | 1 | Marks the final image byte |
| s_ready | output | 1 | Block accepts a byte this cycle |
| init_in | input | 1 | Device ready/error status line (asynchronous) |
| done_in | input | 1 | Device configured status line (asynchronous) |
| prog_n | output | 1 | Active-low program/erase request |
| csw_n | output | 1 | Active-low select-and-write enable |
| dev_data | output | DATA_W | Byte presented to the device |
| dev_wr | output | 1 | One-cycle write strobe for `dev_data` |
| busy | output | 1 | Load in progress |
| result_valid | output | 1 | One-cycle result pulse |
| result_code | output | 3 | 0 none, 1 success, 2 clear timeout, 3 ready timeout, 4 checksum, 5 incomplete |
| byte_count | output | CNT_W | Bytes written in the current or last load |

## Verification
Two stop conditions can land on the same byte: the source's end-of-image marker, and the device's reaction to that byte (DONE rising or INIT falling). The bench provokes this by making the device model trip on exactly the byte that carries `s_last`, in both its successful and its failing form. The outcome is judged by the byte count, which must equal the image length, and by the code, which must follow the line state rather than the marker. Random loads with random trip points, random source gaps and restart pulses issued mid-load cover the remaining combinations against counts and codes computed in the bench.

// File: rtl/cfg_ld_pkg.sv
package cfg_ld_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CS_OFF,
    S_PROG_LOW,
    S_WAIT_INIT,
    S_STREAM,
    S_SETTLE,
    S_DRAIN_ON,
    S_DRAIN_OFF,
    S_REPORT
  } ld_state_t;

  typedef enum logic [2:0] {
    RC_NONE      = 3'd0,
    RC_OK        = 3'd1,
    RC_TMO_CLEAR = 3'd2,
    RC_TMO_INIT  = 3'd3,
    RC_CRC       = 3'd4,
    RC_SHORT     = 3'd5
  } ld_code_t;

  // A wait has run its course once the elapsed tick count reaches the limit.
  function automatic logic tick_expired(input logic [15:0] ticks,
                                        input logic [15:0] limit);
    return ticks >= limit;
  endfunction

  // Streaming ends on device completion, device error, or end of image.
  function automatic logic stream_stop(input logic done_hi,
                                       input logic init_hi,
                                       input logic last_seen);
    return done_hi | ~init_hi | last_seen;
  endfunction

  // Error on the ready line outranks a missing completion.
  function automatic ld_code_t final_code(input logic init_hi,
                                          input logic done_hi);
    if (!init_hi)      return RC_CRC;
    else if (!done_hi) return RC_SHORT;
    else               return RC_OK;
  endfunction

endpackage

// File: rtl/cfg_ld_sync.sv
module cfg_ld_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= RST_VAL;
        else        sr <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= {STAGES{RST_VAL}};
        else        sr <= {sr[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sr[STAGES-1];

endmodule

// File: rtl/cfg_ld_timer.sv
module cfg_ld_timer #(
  parameter int TICK_CYCLES = 16,
  parameter int TICK_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  output logic [TICK_W-1:0] ticks
);

  localparam int CYC_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(TICK_CYCLES - 1);

  logic [CYC_W-1:0] cyc;
  logic             tick_evt;
  logic             sat;

  assign tick_evt = (cyc == CYC_LAST);
  assign sat      = &ticks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc   <= '0;
      ticks <= '0;
    end else if (restart) begin
      cyc   <= '0;
      ticks <= '0;
    end else begin
      cyc <= tick_evt ? '0 : cyc + 1'b1;
      if (tick_evt && !sat) ticks <= ticks + 1'b1;
    end
  end

  // R6
  tick_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> ticks >= $past(ticks));

endmodule

// File: rtl/cfg_ld_bytes.sv
module cfg_ld_bytes #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              accept,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dev_data,
  output logic              dev_wr,
  output logic [CNT_W-1:0]  count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_data <= '0;
      dev_wr   <= 1'b0;
      count    <= '0;
    end else begin
      dev_wr <= accept;
      if (accept) dev_data <= din;
      if (clear)       count <= '0;
      else if (accept) count <= count + 1'b1;
    end
  end

  // R4
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> dev_wr && (count == $past(count) + 1'b1));

  // R8
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> count == '0);

endmodule

// File: rtl/cfg_ld_seq.sv
module cfg_ld_seq
  import cfg_ld_pkg::*;
#(
  parameter int WAIT_TICKS  = 10,
  parameter int DRAIN_TICKS = 2,
  parameter int SETTLE_LAST = 3,
  parameter int TICK_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              s_valid,
  input  logic              s_last,
  input  logic              init_s,
  input  logic              done_s,
  input  logic [TICK_W-1:0] ticks,
  output logic              s_ready,
  output logic              accept,
  output logic              clear_cnt,
  output logic              timer_restart,
  output logic              prog_n,
  output logic              csw_n,
  output logic              busy,
  output logic              result_valid,
  output logic [2:0]        result_code
);

  localparam int SET_W = $clog2(SETTLE_LAST + 1);
  localparam logic [SET_W-1:0] SET_END   = SET_W'(SETTLE_LAST);
  localparam logic [15:0]      WAIT_LIM  = 16'(WAIT_TICKS);
  localparam logic [15:0]      DRAIN_LIM = 16'(DRAIN_TICKS);

  ld_state_t        st, nxt;
  ld_code_t         code_q, code_d;
  logic             last_q, last_d;
  logic [SET_W-1:0] settle_q;

  // Named internal events
  logic line_stop;
  logic wait_over;
  logic drain_over;
  logic settle_done;
  logic cs_active_nxt;

  assign line_stop   = stream_stop(done_s, init_s, 1'b0);
  assign wait_over   = tick_expired(16'(ticks), WAIT_LIM);
  assign drain_over  = tick_expired(16'(ticks), DRAIN_LIM);
  assign settle_done = (settle_q == SET_END);

  always_comb begin
    nxt       = st;
    code_d    = code_q;
    last_d    = last_q;
    clear_cnt = 1'b0;
    case (st)
      S_IDLE: if (start) begin
        nxt       = S_CS_OFF;
        code_d    = RC_NONE;
        last_d    = 1'b0;
        clear_cnt = 1'b1;
      end
      S_CS_OFF: nxt = S_PROG_LOW;
      S_PROG_LOW: begin
        if (!init_s && !done_s) nxt = S_WAIT_INIT;
        else if (wait_over) begin
          nxt    = S_REPORT;
          code_d = RC_TMO_CLEAR;
        end
      end
      S_WAIT_INIT: begin
        if (init_s) nxt = S_STREAM;
        else if (wait_over) begin
          nxt    = S_REPORT;
          code_d = RC_TMO_INIT;
        end
      end
      S_STREAM: begin
        if (line_stop) nxt = S_DRAIN_ON;
        else if (s_valid) begin
          nxt    = S_SETTLE;
          last_d = s_last;
        end
      end
      S_SETTLE: if (settle_done)
        nxt = stream_stop(done_s, init_s, last_q) ? S_DRAIN_ON : S_STREAM;
      S_DRAIN_ON: if (drain_over) nxt = S_DRAIN_OFF;
      S_DRAIN_OFF: if (drain_over) begin
        nxt    = S_REPORT;
        code_d = final_code(init_s, done_s);
      end
      S_REPORT: nxt = S_IDLE;
      default:  nxt = S_IDLE;
    endcase
  end

  assign cs_active_nxt = (nxt == S_STREAM) || (nxt == S_SETTLE) ||
                         (nxt == S_DRAIN_ON);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      code_q   <= RC_NONE;
      last_q   <= 1'b0;
      settle_q <= '0;
      prog_n   <= 1'b1;
      csw_n    <= 1'b1;
    end else begin
      st     <= nxt;
      code_q <= code_d;
      last_q <= last_d;
      if (st != S_SETTLE)   settle_q <= '0;
      else if (!settle_done) settle_q <= settle_q + 1'b1;
      prog_n <= (nxt != S_PROG_LOW);
      csw_n  <= !cs_active_nxt;
    end
  end

  assign timer_restart = (nxt != st);
  assign s_ready       = (st == S_STREAM) && !line_stop;
  assign accept        = s_ready && s_valid;
  assign busy          = (st != S_IDLE);
  assign result_valid  = (st == S_REPORT);
  assign result_code   = code_q;

  // R2
  prog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PROG_LOW && (init_s || done_s) && !wait_over) |=> !prog_n);

  // R4
  csw_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !csw_n |-> prog_n);

  // R5
  ready_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !s_ready);

  // R8
  report_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid && prog_n && csw_n && !busy);

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> st != S_CS_OFF);

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader #(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 16,
  parameter int TICK_CYCLES = 16,
  parameter int WAIT_TICKS  = 10,
  parameter int DRAIN_TICKS = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_valid,
  input  logic              s_last,
  output logic              s_ready,
  input  logic              init_in,
  input  logic              done_in,
  output logic              prog_n,
  output logic              csw_n,
  output logic [DATA_W-1:0] dev_data,
  output logic              dev_wr,
  output logic              busy,
  output logic              result_valid,
  output logic [2:0]        result_code,
  output logic [CNT_W-1:0]  byte_count
);

  localparam int MAX_LIM     = (WAIT_TICKS > DRAIN_TICKS) ? WAIT_TICKS : DRAIN_TICKS;
  localparam int TICK_W      = $clog2(MAX_LIM + 2);
  localparam int SETTLE_LAST = SYNC_STAGES + 1;

  logic              init_s, done_s;
  logic              accept, clear_cnt, timer_restart;
  logic [TICK_W-1:0] ticks;

  cfg_ld_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_init (
    .clk(clk), .rst_n(rst_n), .d(init_in), .q(init_s));

  cfg_ld_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_done (
    .clk(clk), .rst_n(rst_n), .d(done_in), .q(done_s));

  cfg_ld_timer #(.TICK_CYCLES(TICK_CYCLES), .TICK_W(TICK_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(timer_restart), .ticks(ticks));

  cfg_ld_seq #(
    .WAIT_TICKS(WAIT_TICKS), .DRAIN_TICKS(DRAIN_TICKS),
    .SETTLE_LAST(SETTLE_LAST), .TICK_W(TICK_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .s_valid(s_valid),
    .s_last(s_last), .init_s(init_s), .done_s(done_s), .ticks(ticks),
    .s_ready(s_ready), .accept(accept), .clear_cnt(clear_cnt),
    .timer_restart(timer_restart), .prog_n(prog_n), .csw_n(csw_n),
    .busy(busy), .result_valid(result_valid), .result_code(result_code));

  cfg_ld_bytes #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_bytes (
    .clk(clk), .rst_n(rst_n), .clear(clear_cnt), .accept(accept),
    .din(s_data), .dev_data(dev_data), .dev_wr(dev_wr), .count(byte_count));

  // R4
  wr_under_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_wr |-> !csw_n);

  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> prog_n && csw_n && !s_ready);

endmodule

// File: tb/sim_cfg_loader.sv
`timescale 1ns/1ps
module sim_cfg_loader;

  localparam int T     = 4;
  localparam int WAITT = 10;
  localparam int DRT   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] s_data;
  logic s_valid, s_last, s_ready;
  logic init_m, done_m;
  logic prog_n, csw_n, dev_wr, busy, result_valid;
  logic [7:0] dev_data;
  logic [2:0] result_code;
  logic [15:0] byte_count;

  always #10 clk = ~clk;

  cfg_loader #(.TICK_CYCLES(T), .WAIT_TICKS(WAITT), .DRAIN_TICKS(DRT)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .s_data(s_data),
    .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
    .init_in(init_m), .done_in(done_m), .prog_n(prog_n), .csw_n(csw_n),
    .dev_data(dev_data), .dev_wr(dev_wr), .busy(busy),
    .result_valid(result_valid), .result_code(result_code),
    .byte_count(byte_count));

  int checks = 0, errors = 0;
  bit finished = 0;

  // source
  logic [7:0] src_mem [0:63];
  int  src_len = 0, src_idx = 0;
  bit  src_on = 0, gap_ok = 1, clr_mon = 0;
  int  gap_pct = 0;
  assign s_valid = src_on && (src_idx < src_len) && gap_ok;
  assign s_data  = src_mem[src_idx];
  assign s_last  = (src_idx == src_len - 1);

  // device model settings
  bit m_sc = 0, m_sd = 0, m_si = 0, m_kind = 1;
  int m_trip = 0;
  int rc = 0, wc = 0;
  bit cleared = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      init_m <= 1'b1; done_m <= 1'b1; cleared <= 0; rc <= 0; wc <= 0;
    end else if (!prog_n) begin
      rc <= 0; wc <= 0;
      if (!m_sc) begin
        init_m <= 1'b0;
        if (!m_sd) done_m <= 1'b0;
        cleared <= 1;
      end
    end else begin
      if (cleared) begin
        if (rc < 3) rc <= rc + 1;
        else if (!m_si) begin init_m <= 1'b1; cleared <= 0; end
      end
      if (dev_wr) begin
        wc <= wc + 1;
        if (wc + 1 == m_trip) begin
          if (m_kind) done_m <= 1'b1; else init_m <= 1'b0;
        end
      end
    end
  end

  // monitors
  int falls = 0, data_bad = 0, wr_idx = 0, hi_cnt = 0;
  bit seen_cs = 0, prog_prev = 1;
  always @(posedge clk) begin
    prog_prev <= prog_n;
    if (clr_mon) begin
      src_idx <= 0; falls <= 0; data_bad <= 0; wr_idx <= 0;
    end else begin
      if (s_valid && s_ready) src_idx <= src_idx + 1;
      if (prog_prev && !prog_n) falls <= falls + 1;
      if (dev_wr) begin
        if (dev_data !== src_mem[wr_idx]) data_bad <= data_bad + 1;
        wr_idx <= wr_idx + 1;
      end
    end
  end
  always @(negedge clk) begin
    gap_ok <= (($urandom % 100) >= gap_pct);
    if (clr_mon) begin
      hi_cnt <= 0; seen_cs <= 0;
    end else begin
      if (busy && !csw_n) seen_cs <= 1;
      if (busy && csw_n && seen_cs && !result_valid) hi_cnt <= hi_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_count(int len, int trip, bit sc, bit sd, bit si);
    if (sc || sd || si) return 0;
    return (trip >= 1 && trip <= len) ? trip : len;
  endfunction

  function automatic int exp_code(int len, int trip, bit kind, bit sc, bit sd, bit si);
    if (sc || sd) return 2;
    if (si) return 3;
    if (trip >= 1 && trip <= len) return kind ? 1 : 4;
    return 5;
  endfunction

  task automatic run_load(int len, int trip, bit kind, bit sc, bit sd, bit si,
                          int gap, bit extra);
    bit got = 0, xs = 0;
    int code_v = 0, cnt_v = 0, ec, en;
    for (int i = 0; i < 64; i++) src_mem[i] = 8'($urandom);
    src_len = len; m_trip = trip; m_kind = kind;
    m_sc = sc; m_sd = sd; m_si = si; gap_pct = gap;
    @(negedge clk); clr_mon = 1;
    @(negedge clk); clr_mon = 0; src_on = 1; start = 1;
    @(negedge clk); start = 0;
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      if (extra && !xs && !csw_n) begin start = 1; xs = 1; end
      else start = 0;
      if (result_valid) begin
        got = 1; code_v = int'(result_code); cnt_v = int'(byte_count);
        break;
      end
    end
    start = 0;
    ec = exp_code(len, trip, kind, sc, sd, si);
    en = exp_count(len, trip, sc, sd, si);
    chk(got, "R8 result pulse", int'(got), 1);
    // R2 R3 R7 code
    chk(code_v == ec, (ec == 2) ? "R2 code" : (ec == 3) ? "R3 code" : "R7 code", code_v, ec);
    chk(cnt_v == en, "R5 byte count", cnt_v, en);
    @(negedge clk);
    chk(falls == 1, extra ? "R9 prog falls" : "R2 prog falls", falls, 1);
    chk(data_bad == 0 && wr_idx == en, "R4 data order", data_bad * 1000 + wr_idx, en);
    if (ec != 2 && ec != 3)
      chk(hi_cnt == DRT * T + 1, "R6 drain", hi_cnt, DRT * T + 1);
    chk(!result_valid && prog_n && csw_n && !busy, "R8 idle after", {28'd0, result_valid, prog_n, csw_n, busy}, 6);
    chk(int'(result_code) == ec && int'(byte_count) == en, "R8 hold", int'(result_code), ec);
    src_on = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(prog_n && csw_n && !s_ready && !busy && !result_valid && !dev_wr,
        "R1 reset lines", {26'd0, prog_n, csw_n, s_ready, busy, result_valid, dev_wr}, 48);
    chk(byte_count == 0 && result_code == 0, "R1 reset values", int'(byte_count), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // directed
    run_load(5, 0, 1, 1, 0, 0, 0, 0);   // R2 clear never seen
    run_load(5, 0, 1, 0, 1, 0, 0, 0);   // R2 done stays high
    run_load(5, 0, 1, 0, 0, 1, 0, 0);   // R3 ready never returns
    run_load(8, 8, 1, 0, 0, 0, 0, 0);   // R5 last and done same byte
    run_load(8, 8, 0, 0, 0, 0, 0, 0);   // R7 last and init drop same byte
    run_load(12, 4, 0, 0, 0, 0, 0, 0);  // R7 checksum
    run_load(6, 0, 1, 0, 0, 0, 30, 0);  // R7 incomplete
    run_load(1, 1, 1, 0, 0, 0, 0, 0);   // R5 single byte
    run_load(20, 9, 1, 0, 0, 0, 20, 1); // R9 start during load
    // random
    for (int k = 0; k < 30; k++) begin
      int len, trip;
      len  = 1 + int'($urandom % 24);
      trip = int'($urandom % (len + 4));
      run_load(len, trip, 1'($urandom), 0, 0, 0, int'($urandom % 50), 1'($urandom));
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule